// File: doc/BRIEF.md
# Transmit Descriptor-Ring DMA Channel

This block moves packets from memory to a byte stream. Software builds a ring of eight-byte descriptors in memory and writes the ring's base address. It then sets the enable bit. The channel walks the ring from its current position. For each descriptor that software owns, it reads the buffer the descriptor points to and sends those bytes on a valid/ready stream, marking the packet boundaries that the descriptor's status asks for. When a descriptor is done, the channel writes it back with the ownership bit cleared, so that software can tell the buffer is free.

The channel stops by itself when it reaches a descriptor that software has not handed over. Software can also stop it with one of two halt requests. A burst halt stops the channel after the current descriptor. A packet halt stops it after the current packet. In both cases the enable bit reads back as 0 once the channel has stopped. The channel does not compute a CRC. It only passes on, with the last byte, the descriptor's request that one be appended.

Top module: `txring_dma`

## Requirements
- R1: After reset the channel is stopped. Control readback is 0, ring base and current pointer read 0, and `tx_valid` and `mem_req` are low.
- R2: A write to register 1 while the channel is stopped loads both the ring base and the current pointer (register 2), with the low three bits forced to 0. While the channel is running, such a write is ignored.
- R3: Writing 1 to control bit 0 starts the channel at the current pointer. Descriptor word 0 at the pointer holds status in bits 31:16 and length in bits 15:0. The word at pointer+4 holds the buffer byte address. A memory request holds its address, data and direction until `mem_ack`.
- R4: A fetched descriptor whose status bit 15 (owned) is 0 stops the channel. Enable reads 0, no beat is sent, no writeback happens, and the pointer is unchanged.
- R5: Buffer bytes go out in ascending address order, starting at any byte offset. They are taken little-endian from 32-bit memory words.
- R6: `tx_sop` is set on a descriptor's first beat when status bit 13 is 1. `tx_eop` is set on its last beat when bit 14 is 1. `tx_crc` is set on its last beat when bit 8 is 1.
- R7: After its last byte is accepted, a descriptor's word 0 is written back with bit 31 cleared and all other bits unchanged.
- R8: After writeback, the pointer advances by 8. If status bit 12 (wrap) is set, it returns to the ring base instead.
- R9: A zero-length descriptor is written back without any beat on the stream.
- R10: Control bit 2 (burst halt), written while running, stops the channel after the writeback of the current descriptor. Control bit 0 then reads 0.
- R11: Control bit 1 (packet halt), written while running, keeps the channel going until a descriptor with status bit 14 has been written back, and then stops it.
- R12: While `tx_valid` is high and `tx_ready` is low, the beat and its flags stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 ring base, 2 current pointer |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected register value |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| tx_valid | output | 1 | Stream beat valid |
| tx_data | output | 8 | Stream byte |
| tx_sop | output | 1 | First byte of packet |
| tx_eop | output | 1 | Last byte of packet |
| tx_crc | output | 1 | Append CRC request, with last byte |
| tx_ready | input | 1 | Stream sink accepts beat |

## Verification
The hardest cases to reach are the halt requests. Each one has to arrive while a descriptor is in flight and before its writeback. The bench lands them by writing the halt right after the enable. It relies on a descriptor taking at least three memory round trips, each stretched by a pseudo-random acknowledge, so the halt always arrives first. The packet-halt case spreads one packet over two descriptors, so that stopping after the first descriptor instead of the second shows up in the pointer and in the ownership bit left behind. Throttling `tx_ready` with the same generator exercises stalls across word boundaries and on unaligned buffers.

// File: rtl/txring_dma.sv
module txring_dma #(
  parameter int DESC_BYTES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        tx_sop,
  output logic        tx_eop,
  output logic        tx_crc,
  input  logic        tx_ready
);
  localparam int BIT_OWN  = 15;
  localparam int BIT_EOP  = 14;
  localparam int BIT_SOP  = 13;
  localparam int BIT_WRAP = 12;
  localparam int BIT_CRC  = 8;

  typedef enum logic [2:0] {S_IDLE, S_HEAD, S_PTR, S_LOAD, S_SEND, S_BACK} state_t;

  state_t      state;
  logic        run_q, halt_pkt, halt_brst, first_q;
  logic [31:0] ring_base, cur_ptr, baddr, word_q;
  logic [15:0] st_q, len_q, left_q;

  wire ctrl_wr  = reg_wr && reg_addr == 2'd0;
  wire base_wr  = reg_wr && reg_addr == 2'd1 && !run_q;
  wire last_bt  = left_q == 16'd1;
  wire stop_now = halt_brst || (halt_pkt && st_q[BIT_EOP]);

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {29'd0, halt_brst, halt_pkt, run_q};
      2'd1:    reg_rdata = ring_base;
      2'd2:    reg_rdata = cur_ptr;
      default: reg_rdata = 32'd0;
    endcase
  end

  assign mem_req   = state == S_HEAD || state == S_PTR || state == S_LOAD || state == S_BACK;
  assign mem_we    = state == S_BACK;
  assign mem_wdata = {1'b0, st_q[14:0], len_q};

  always_comb begin
    case (state)
      S_PTR:   mem_addr = cur_ptr + 32'd4;
      S_LOAD:  mem_addr = {baddr[31:2], 2'b00};
      default: mem_addr = cur_ptr;
    endcase
  end

  assign tx_valid = state == S_SEND;
  assign tx_data  = word_q[{baddr[1:0], 3'b000} +: 8];
  assign tx_sop   = tx_valid && first_q && st_q[BIT_SOP];
  assign tx_eop   = tx_valid && last_bt && st_q[BIT_EOP];
  assign tx_crc   = tx_valid && last_bt && st_q[BIT_CRC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      run_q     <= 1'b0;
      halt_pkt  <= 1'b0;
      halt_brst <= 1'b0;
      first_q   <= 1'b0;
      ring_base <= 32'd0;
      cur_ptr   <= 32'd0;
      baddr     <= 32'd0;
      word_q    <= 32'd0;
      st_q      <= 16'd0;
      len_q     <= 16'd0;
      left_q    <= 16'd0;
    end else begin
      if (base_wr) begin
        ring_base <= {reg_wdata[31:3], 3'b000};
        cur_ptr   <= {reg_wdata[31:3], 3'b000};
      end
      if (ctrl_wr && run_q) begin
        halt_pkt  <= halt_pkt  | reg_wdata[1];
        halt_brst <= halt_brst | reg_wdata[2];
      end
      case (state)
        S_IDLE: if (ctrl_wr && reg_wdata[0]) begin
          run_q <= 1'b1;
          state <= S_HEAD;
        end
        S_HEAD: if (mem_ack) begin
          if (!mem_rdata[16 + BIT_OWN]) begin
            run_q     <= 1'b0;
            halt_pkt  <= 1'b0;
            halt_brst <= 1'b0;
            state     <= S_IDLE;
          end else begin
            st_q   <= mem_rdata[31:16];
            len_q  <= mem_rdata[15:0];
            left_q <= mem_rdata[15:0];
            state  <= S_PTR;
          end
        end
        S_PTR: if (mem_ack) begin
          baddr   <= mem_rdata;
          first_q <= 1'b1;
          state   <= (len_q == 16'd0) ? S_BACK : S_LOAD;
        end
        S_LOAD: if (mem_ack) begin
          word_q <= mem_rdata;
          state  <= S_SEND;
        end
        S_SEND: if (tx_ready) begin
          baddr   <= baddr + 32'd1;
          left_q  <= left_q - 16'd1;
          first_q <= 1'b0;
          if (last_bt)                 state <= S_BACK;
          else if (baddr[1:0] == 2'd3) state <= S_LOAD;
        end
        S_BACK: if (mem_ack) begin
          cur_ptr <= st_q[BIT_WRAP] ? ring_base : cur_ptr + DESC_BYTES;
          if (stop_now) begin
            run_q     <= 1'b0;
            halt_pkt  <= 1'b0;
            halt_brst <= 1'b0;
            state     <= S_IDLE;
          end else begin
            state <= S_HEAD;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txring_dma_checks.sv
module txring_dma_checks (
  input logic        clk,
  input logic        rst_n,
  input logic        running,
  input logic        brst,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_ack,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [7:0]  tx_data,
  input logic        tx_sop,
  input logic        tx_eop,
  input logic        tx_crc
);
  p_beat_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_sop)
                              && $stable(tx_eop) && $stable(tx_crc));

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !tx_valid && !mem_req);

  p_wb_own_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !mem_wdata[31]);

  p_burst_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    brst && mem_req && mem_we && mem_ack |=> !running);
endmodule

bind txring_dma txring_dma_checks u_checks (
  .clk(clk), .rst_n(rst_n), .running(run_q), .brst(halt_brst),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .tx_sop(tx_sop), .tx_eop(tx_eop), .tx_crc(tx_crc)
);

// File: tb/txring_dma_test.sv
module txring_dma_test;
  logic        clk = 0, rst_n = 0;
  logic        reg_wr = 0;
  logic [1:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        mem_req, mem_we, mem_ack = 0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 0;
  logic        tx_valid, tx_sop, tx_eop, tx_crc, tx_ready = 0;
  logic [7:0]  tx_data;

  localparam logic [15:0] OWN = 16'h8000, EOP = 16'h4000, SOP = 16'h2000,
                          WRAP = 16'h1000, CRC = 16'h0100;

  int checks = 0, errors = 0, cyc = 0;
  logic [31:0] mem [0:255];
  logic [15:0] lfsr = 16'hACE1;
  logic [10:0] expq [$];
  logic        prev_stall = 0;
  logic [10:0] prev_beat = 0;

  always #5 clk = ~clk;

  txring_dma uut (.*);

  always @(posedge clk) begin
    lfsr     <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tx_ready <= lfsr[5] | lfsr[1];
    if (mem_req && !mem_ack && (lfsr[0] | lfsr[3])) begin
      mem_ack <= 1'b1;
      if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[9:2]];
    end else begin
      mem_ack <= 1'b0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: actual cycles %0d expected < 100000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // reference stream model: every accepted beat is compared with the queue
  always @(negedge clk) begin
    if (rst_n && tx_valid) begin
      if (prev_stall) check("R12 held beat", {tx_crc, tx_eop, tx_sop, tx_data}, prev_beat);
      if (tx_ready) begin
        if (expq.size() == 0) check("R5 unexpected beat", {tx_crc, tx_eop, tx_sop, tx_data}, 32'hx);
        else check("R5/R6 beat", {tx_crc, tx_eop, tx_sop, tx_data}, expq.pop_front());
      end
    end
    prev_stall = rst_n && tx_valid && !tx_ready;
    prev_beat  = {tx_crc, tx_eop, tx_sop, tx_data};
  end

  task automatic wreg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0; reg_addr = 0;
  endtask

  task automatic rreg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata; reg_addr = 0;
  endtask

  task automatic put_desc(input int a, input logic [15:0] st, input logic [15:0] ln, input logic [31:0] buf_a);
    mem[a >> 2]       <= {st, ln};
    mem[(a >> 2) + 1] <= buf_a;
  endtask

  task automatic fill(input int a, input int n, input int seed);
    for (int i = 0; i < n; i++) mem[(a + i) >> 2][8 * ((a + i) & 3) +: 8] <= 8'(seed + 7 * i);
  endtask

  task automatic expect_desc(input int a);
    logic [31:0] w0, ba;
    logic [7:0] b;
    w0 = mem[a >> 2]; ba = mem[(a >> 2) + 1];
    for (int i = 0; i < int'(w0[15:0]); i++) begin
      b = mem[(ba + i) >> 2][8 * ((ba + i) & 3) +: 8];
      expq.push_back({(i == int'(w0[15:0]) - 1) && w0[24],
                      (i == int'(w0[15:0]) - 1) && w0[30],
                      (i == 0) && w0[29], b});
    end
  endtask

  task automatic wait_stop();
    logic [31:0] d;
    for (int i = 0; i < 20000; i++) begin
      rreg(2'd0, d);
      if (!d[0]) break;
    end
  endtask

  logic [31:0] v, w_a, w_b, w_c;

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'd0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 tx_valid", {31'd0, tx_valid}, 0);
    check("R1 mem_req", {31'd0, mem_req}, 0);
    rreg(2'd0, v); check("R1 control", v, 0);
    rreg(2'd1, v); check("R1 base", v, 0);
    rreg(2'd2, v); check("R1 pointer", v, 0);

    // ring with unaligned buffer, zero-length middle, wrap on third
    put_desc(32'h100, OWN | SOP, 16'd5, 32'h201);
    put_desc(32'h108, OWN, 16'd0, 32'h260);
    put_desc(32'h110, OWN | EOP | CRC | WRAP, 16'd6, 32'h302);
    fill(32'h201, 5, 17); fill(32'h302, 6, 90);
    wreg(2'd1, 32'h105);
    rreg(2'd2, v); check("R2 pointer load", v, 32'h100);
    rreg(2'd1, v); check("R2 base load", v, 32'h100);
    w_a = mem[32'h100 >> 2]; w_b = mem[32'h108 >> 2]; w_c = mem[32'h110 >> 2];
    expect_desc(32'h100); expect_desc(32'h108); expect_desc(32'h110);
    wreg(2'd0, 32'h1);
    wreg(2'd1, 32'h180);
    rreg(2'd1, v); check("R2 base write while running", v, 32'h100);
    wait_stop();
    check("R7 writeback d0", mem[32'h100 >> 2], w_a & 32'h7fffffff);
    check("R9 zero-length writeback", mem[32'h108 >> 2], w_b & 32'h7fffffff);
    check("R7 writeback d2", mem[32'h110 >> 2], w_c & 32'h7fffffff);
    rreg(2'd2, v); check("R8 wrap to base / R4 pointer kept", v, 32'h100);
    check("R5 all beats sent", expq.size(), 0);

    // burst halt
    for (int k = 0; k < 3; k++) begin
      put_desc(32'h40 + 8 * k, OWN | SOP | EOP, 16'd3, 32'h240 + 4 * k);
      fill(32'h240 + 4 * k, 3, 40 * k + 3);
    end
    wreg(2'd1, 32'h40);
    @(negedge clk);
    expect_desc(32'h40);
    wreg(2'd0, 32'h1);
    wreg(2'd0, 32'h4);
    wait_stop();
    rreg(2'd0, v); check("R10 enable cleared", v, 0);
    rreg(2'd2, v); check("R10 R8 pointer after one descriptor", v, 32'h48);
    check("R10 next descriptor still owned", {31'd0, mem[32'h48 >> 2][31]}, 1);
    check("R10 beats", expq.size(), 0);

    // packet halt across a two-descriptor packet
    put_desc(32'h80, OWN | SOP, 16'd2, 32'h280);
    put_desc(32'h88, OWN | EOP | CRC, 16'd2, 32'h287);
    put_desc(32'h90, OWN | SOP | EOP, 16'd1, 32'h290);
    fill(32'h280, 2, 200); fill(32'h287, 2, 111); fill(32'h290, 1, 5);
    wreg(2'd1, 32'h80);
    @(negedge clk);
    expect_desc(32'h80); expect_desc(32'h88);
    wreg(2'd0, 32'h1);
    wreg(2'd0, 32'h2);
    wait_stop();
    rreg(2'd2, v); check("R11 pointer after packet end", v, 32'h90);
    check("R11 first part returned", {31'd0, mem[32'h80 >> 2][31]}, 0);
    check("R11 third descriptor owned", {31'd0, mem[32'h90 >> 2][31]}, 1);
    check("R11 beats", expq.size(), 0);

    // unowned descriptor at start
    wreg(2'd1, 32'hC0);
    wreg(2'd0, 32'h1);
    wait_stop();
    rreg(2'd0, v); check("R4 enable cleared", v, 0);
    rreg(2'd2, v); check("R4 pointer unchanged", v, 32'hC0);
    check("R4 descriptor untouched", mem[32'hC0 >> 2], 0);
    check("R4 no beats", expq.size(), 0);

    // restart resumes at current ring position (R3)
    put_desc(32'hC0, OWN | SOP | EOP | WRAP, 16'd4, 32'h2C0);
    fill(32'h2C0, 4, 60);
    @(negedge clk);
    expect_desc(32'hC0);
    wreg(2'd0, 32'h1);
    wait_stop();
    check("R3 resume from pointer", expq.size(), 0);
    check("R3 writeback", {31'd0, mem[32'hC0 >> 2][31]}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule